// File: doc/BRIEF.md
# In-Frame Response Transmit Controller

This block sequences the transmission of a multi-byte in-frame response on a J1850-style multiplex bus. It works at byte and symbol granularity. A host loads bytes one at a time into a single holding register. It requests a response either with or without a trailing CRC byte, and marks the final byte with an end-of-data request. Once the frame's end-of-data has been seen on the bus, the controller emits a normalization symbol, then the data bytes, then an optional inverted CRC-8, and finally an end-of-data symbol.

Bus-side symbol timing, bit arbitration and reception are outside the block. Each outgoing symbol is offered on a valid/kind/data bundle and is held until the transmitter acknowledges it. The receive side reports start of frame, each header byte, a valid end-of-data, bus errors and arbitration loss. The host paces the stream through a transmit-data-empty flag. Missing a byte is an underrun and abandons the response. Losing arbitration on the final bit of a byte makes the controller drive two extra logic-1 bits, so that downstream receivers see a byte-boundary fault.

Top module: `ifr_tx_ctrl`

## Requirements
- R1: A request is accepted only when a frame has been opened by `rx_sof_i` and no valid end-of-data has been reported since. A request at any other time leaves both request flags at 0 and produces no symbol.
- R2: After an accepted request, the first symbol offered once end-of-data is reported has kind 0 (normalization) and data 0. It is followed by a kind 1 (data) symbol carrying the byte held in the host register.
- R3: `tde_o` is 1 in the cycle after a held byte is moved into the shift register. It is 0 in the cycle after any host write.
- R4: With `eod_req_i` given after the last write, the byte held at that moment is the last data symbol. In no-CRC mode it is followed directly by a kind 3 (end-of-data) symbol with data 0.
- R5: In CRC mode a kind 2 symbol precedes end-of-data, and this also applies to a single data byte. Its data is the bitwise inverse of a CRC-8 with polynomial 0x1D and initial value 0xFF, computed MSB first over the data bytes.
- R6: If the transmitter acknowledges a data symbol while the host register is empty and no end-of-data request is pending, the response is abandoned. The request flag clears and no further symbol is offered.
- R7: `bus_err_i` during an active response clears the request flag and withdraws any offered symbol in the next cycle.
- R8: Arbitration loss during a symbol clears the request flag and the byte is not resent. If `arb_last_bit_i` is 1, a kind 4 symbol (two logic-1 bits) is offered and the block idles after its acknowledgement. Otherwise nothing further is offered.
- R9: The request flag clears in the cycle after the end-of-data symbol is acknowledged.
- R10: Header bytes plus response bytes, the CRC byte included, never exceed `MAX_FRAME_BYTES`. A byte that would exceed the limit aborts the response instead of being offered.
- R11: If both request inputs are asserted together, CRC mode is chosen. Request inputs have no effect while a response is active.
- R12: An offered symbol keeps its kind and data until it is acknowledged or aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_wr_i | input | 1 | Host write strobe for the holding register |
| data_i | input | 8 | Host byte to hold |
| req_nocrc_i | input | 1 | Request a response without CRC |
| req_crc_i | input | 1 | Request a response with CRC |
| eod_req_i | input | 1 | Host marks the held byte as last |
| tde_o | output | 1 | Transmit-data-empty flag |
| req_nocrc_o | output | 1 | No-CRC request active |
| req_crc_o | output | 1 | CRC request active |
| rx_sof_i | input | 1 | Frame start seen on the bus |
| rx_byte_i | input | 1 | Header byte seen on the bus |
| rx_eod_i | input | 1 | Valid end-of-data received without CRC error |
| bus_err_i | input | 1 | Bus error detected |
| arb_lost_i | input | 1 | Arbitration lost on the current symbol |
| arb_last_bit_i | input | 1 | Loss occurred on the last bit of a byte |
| sym_ack_i | input | 1 | Transmitter finished the offered symbol |
| sym_valid_o | output | 1 | Symbol offered |
| sym_kind_o | output | 3 | Symbol kind: 0 norm, 1 data, 2 CRC, 3 end-of-data, 4 two ones |
| sym_data_o | output | 8 | Byte for data or CRC symbols, else 0 |

## Verification
Several properties are checked on every cycle. Offered symbols stay stable until they are acknowledged. A host write clears the empty flag, and a load sets it. Bus errors and arbitration loss end the response in the next cycle. Late requests are refused, a request input is ignored while a response is active, and the frame count stays bounded. The ordering of symbols, the CRC value, underrun detection and the point at which the length limit aborts can only be shown by the bench. It runs complete responses with random header and payload lengths and acknowledge delays, plus directed aborts, and compares each offered symbol with a sequence it computes on its own.

// File: rtl/ifr_tx_pkg.sv
package ifr_tx_pkg;
  typedef enum logic [2:0] {
    SYM_NORM = 3'd0,
    SYM_DATA = 3'd1,
    SYM_CRC  = 3'd2,
    SYM_EOD  = 3'd3,
    SYM_ONES = 3'd4
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_NB, ST_DATA, ST_CRC, ST_EOD, ST_ONES
  } ifr_st_e;

  // byte-wide CRC update, MSB first
  function automatic logic [7:0] crc8_byte(logic [7:0] acc, logic [7:0] d,
                                           logic [7:0] poly);
    logic [7:0] r;
    r = acc ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/ifr_crc8.sv
module ifr_crc8 #(
  parameter logic [7:0] POLY = 8'h1D,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic [7:0] tx_o
);
  logic [7:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= INIT;
    else if (init_i) acc_q <= INIT;
    else if (upd_i)  acc_q <= ifr_tx_pkg::crc8_byte(acc_q, byte_i, POLY);
  end

  assign tx_o = ~acc_q;
endmodule

// File: rtl/ifr_len_guard.sv
module ifr_len_guard #(
  parameter int MAX_BYTES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hdr_i,
  input  logic ifr_i,
  output logic full_o
);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_BYTES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if ((hdr_i | ifr_i) && !full_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q >= LIMIT);

  a_r10_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/ifr_data_hold.sv
module ifr_data_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          tde_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      tde_o  <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
      tde_o  <= 1'b0;
    end else if (take_i) begin
      full_o <= 1'b0;
      tde_o  <= 1'b1;
    end else if (clr_i) begin
      full_o <= 1'b0;
      tde_o  <= 1'b0;
    end
  end

  a_r3_write_clears_tde: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !tde_o);
  a_r3_take_sets_tde: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i) |=> tde_o && !full_o);
endmodule

// File: rtl/ifr_tx_ctrl.sv
module ifr_tx_ctrl #(
  parameter int         MAX_FRAME_BYTES = 12,
  parameter logic [7:0] CRC_POLY        = 8'h1D,
  parameter logic [7:0] CRC_INIT        = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       data_wr_i,
  input  logic [7:0] data_i,
  input  logic       req_nocrc_i,
  input  logic       req_crc_i,
  input  logic       eod_req_i,
  output logic       tde_o,
  output logic       req_nocrc_o,
  output logic       req_crc_o,
  input  logic       rx_sof_i,
  input  logic       rx_byte_i,
  input  logic       rx_eod_i,
  input  logic       bus_err_i,
  input  logic       arb_lost_i,
  input  logic       arb_last_bit_i,
  input  logic       sym_ack_i,
  output logic       sym_valid_o,
  output logic [2:0] sym_kind_o,
  output logic [7:0] sym_data_o
);
  import ifr_tx_pkg::*;
  localparam int BW = 8;

  ifr_st_e       state_q, state_d;
  logic          mode_q, mode_d;          // 1: CRC appended
  logic          eod_pend_q, eod_pend_d;
  logic [BW-1:0] sh_q, sh_d;
  logic          sof_seen_q, eod_seen_q;
  logic          take, crc_init, crc_upd, ifr_inc, end_ifr;
  logic [BW-1:0] hold_data, crc_tx;
  logic          hold_full, len_full;
  logic          active_st, xmit_st, window, any_req;

  assign active_st = state_q inside {ST_ARMED, ST_NB, ST_DATA, ST_CRC, ST_EOD};
  assign xmit_st   = state_q inside {ST_NB, ST_DATA, ST_CRC, ST_EOD};
  assign window    = sof_seen_q & ~eod_seen_q;
  assign any_req   = req_crc_i | req_nocrc_i;

  // bus-side frame window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_seen_q <= 1'b0;
      eod_seen_q <= 1'b0;
    end else if (rx_sof_i) begin
      sof_seen_q <= 1'b1;
      eod_seen_q <= 1'b0;
    end else if (rx_eod_i && sof_seen_q) begin
      eod_seen_q <= 1'b1;
    end
  end

  ifr_data_hold #(.DW(BW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (data_wr_i),
    .wdata_i (data_i),
    .take_i  (take),
    .clr_i   (end_ifr),
    .data_o  (hold_data),
    .full_o  (hold_full),
    .tde_o   (tde_o)
  );

  ifr_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .upd_i  (crc_upd),
    .byte_i (hold_data),
    .tx_o   (crc_tx)
  );

  ifr_len_guard #(.MAX_BYTES(MAX_FRAME_BYTES)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rx_sof_i),
    .hdr_i  (rx_byte_i & window),
    .ifr_i  (ifr_inc),
    .full_o (len_full)
  );

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    sh_d       = sh_q;
    take       = 1'b0;
    crc_init   = 1'b0;
    crc_upd    = 1'b0;
    ifr_inc    = 1'b0;
    end_ifr    = 1'b0;
    eod_pend_d = eod_pend_q | (eod_req_i & active_st);
    if (state_q == ST_IDLE) begin
      if (any_req && window) begin
        state_d    = ST_ARMED;
        mode_d     = req_crc_i;   // CRC request wins a tie
        crc_init   = 1'b1;
        eod_pend_d = 1'b0;
      end
    end else if (bus_err_i) begin
      state_d = ST_IDLE;
      end_ifr = 1'b1;
    end else if (arb_lost_i && xmit_st) begin
      end_ifr = 1'b1;
      sh_d    = '0;
      state_d = arb_last_bit_i ? ST_ONES : ST_IDLE;
    end else begin
      case (state_q)
        ST_ARMED: if (rx_eod_i || eod_seen_q) begin
          state_d = ST_NB;
          sh_d    = '0;
        end
        ST_NB, ST_DATA: if (sym_ack_i) begin
          if (hold_full) begin
            if (len_full) begin
              state_d = ST_IDLE;
              end_ifr = 1'b1;
            end else begin
              state_d = ST_DATA;
              sh_d    = hold_data;
              take    = 1'b1;
              crc_upd = 1'b1;
              ifr_inc = 1'b1;
            end
          end else if (state_q == ST_DATA && eod_pend_q) begin
            if (!mode_q) begin
              state_d = ST_EOD;
              sh_d    = '0;
            end else if (len_full) begin
              state_d = ST_IDLE;
              end_ifr = 1'b1;
            end else begin
              state_d = ST_CRC;
              sh_d    = crc_tx;
              ifr_inc = 1'b1;
            end
          end else begin
            // underrun
            state_d = ST_IDLE;
            end_ifr = 1'b1;
          end
        end
        ST_CRC: if (sym_ack_i) begin
          state_d = ST_EOD;
          sh_d    = '0;
        end
        ST_EOD: if (sym_ack_i) begin
          state_d = ST_IDLE;
          end_ifr = 1'b1;
        end
        ST_ONES: if (sym_ack_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= 1'b0;
      eod_pend_q <= 1'b0;
      sh_q       <= '0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      eod_pend_q <= eod_pend_d;
      sh_q       <= sh_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_NB:   sym_kind_o = SYM_NORM;
      ST_DATA: sym_kind_o = SYM_DATA;
      ST_CRC:  sym_kind_o = SYM_CRC;
      ST_EOD:  sym_kind_o = SYM_EOD;
      ST_ONES: sym_kind_o = SYM_ONES;
      default: sym_kind_o = SYM_NORM;
    endcase
  end

  assign sym_valid_o = xmit_st | (state_q == ST_ONES);
  assign sym_data_o  = sh_q;
  assign req_crc_o   = active_st & mode_q;
  assign req_nocrc_o = active_st & ~mode_q;

  a_r1_late_req_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !window && any_req) |=> !(req_crc_o || req_nocrc_o));
  a_r11_busy_req_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_crc_o && req_nocrc_i) |=> !req_nocrc_o);
  a_r12_symbol_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && !sym_ack_i && !bus_err_i && !arb_lost_i)
      |=> sym_valid_o && $stable(sym_kind_o) && $stable(sym_data_o));
  a_r7_bus_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_i && (sym_valid_o || req_crc_o || req_nocrc_o))
      |=> !sym_valid_o && !req_crc_o && !req_nocrc_o);
  a_r8_arb_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_i && xmit_st && !bus_err_i && !arb_last_bit_i) |=> !sym_valid_o);
  a_r8_arb_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_i && xmit_st && !bus_err_i && arb_last_bit_i)
      |=> sym_valid_o && sym_kind_o == SYM_ONES && !req_crc_o && !req_nocrc_o);
  a_r9_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EOD && sym_ack_i && !bus_err_i && !arb_lost_i)
      |=> !req_crc_o && !req_nocrc_o);
endmodule

// File: tb/tb_ifr_tx_ctrl.sv
module tb_ifr_tx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic data_wr_i = 0, req_nocrc_i = 0, req_crc_i = 0, eod_req_i = 0;
  logic [7:0] data_i = '0;
  logic rx_sof_i = 0, rx_byte_i = 0, rx_eod_i = 0, bus_err_i = 0;
  logic arb_lost_i = 0, arb_last_bit_i = 0, sym_ack_i = 0;
  logic tde_o, req_nocrc_o, req_crc_o, sym_valid_o;
  logic [2:0] sym_kind_o;
  logic [7:0] sym_data_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pl [0:15];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ifr_tx_ctrl #(.MAX_FRAME_BYTES(MAXB)) dut (.*);

  task automatic step(); @(negedge clk_i); endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(logic [7:0] c, logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h1D;
    end
    return c;
  endfunction

  task automatic open_frame(int n_hdr);
    rx_sof_i = 1; step(); rx_sof_i = 0;
    if (n_hdr > 0) begin rx_byte_i = 1; repeat (n_hdr) step(); rx_byte_i = 0; end
  endtask
  task automatic host_write(logic [7:0] b);
    data_i = b; data_wr_i = 1; step(); data_wr_i = 0;
  endtask
  task automatic request(bit crc);
    if (crc) req_crc_i = 1; else req_nocrc_i = 1;
    step(); req_crc_i = 0; req_nocrc_i = 0;
  endtask
  task automatic bus_eod(); rx_eod_i = 1; step(); rx_eod_i = 0; endtask
  task automatic ack();
    repeat ($urandom_range(0, 2)) step();
    sym_ack_i = 1; step(); sym_ack_i = 0;
  endtask
  task automatic wait_sym();
    for (int t = 0; t < 40 && !sym_valid_o; t++) step();
  endtask
  task automatic expect_sym(logic [2:0] k, logic [7:0] d, string tag);
    wait_sym();
    chk(sym_valid_o, {tag, " valid"}, sym_valid_o, 1);
    chk(sym_kind_o == k, {tag, " kind"}, sym_kind_o, k);
    chk(sym_data_o == d, {tag, " data"}, sym_data_o, d);
  endtask
  task automatic expect_idle(string tag);
    chk(!sym_valid_o, {tag, " valid"}, sym_valid_o, 0);
    chk(!req_crc_o && !req_nocrc_o, {tag, " req"}, {req_crc_o, req_nocrc_o}, 0);
  endtask

  // full response; pl[] holds payload
  task automatic run_ifr(int n_hdr, int n, bit crc);
    logic [7:0] c = 8'hFF;
    open_frame(n_hdr);
    host_write(pl[0]);
    request(crc);
    chk(crc ? req_crc_o : req_nocrc_o, "R1 accept", {req_crc_o, req_nocrc_o}, crc ? 2 : 1);
    bus_eod();
    expect_sym(3'd0, 8'h00, "R2 norm");
    ack();
    for (int k = 0; k < n; k++) begin
      if (n_hdr + k >= MAXB) begin expect_idle("R10 limit data"); return; end
      expect_sym(3'd1, pl[k], "R2 data");
      chk(tde_o, "R3 tde set", tde_o, 1);
      c = crc_ref(c, pl[k]);
      if (k < n - 1) begin
        host_write(pl[k+1]);
        chk(!tde_o, "R3 tde clr", tde_o, 0);
      end else begin
        eod_req_i = 1; step(); eod_req_i = 0;
      end
      ack();
    end
    if (crc) begin
      if (n_hdr + n >= MAXB) begin expect_idle("R10 limit crc"); return; end
      expect_sym(3'd2, ~c, "R5 crc");
      ack();
    end
    expect_sym(3'd3, 8'h00, "R4 eod");
    ack();
    expect_idle("R9 done");
  endtask

  // opens a frame and runs to the first data symbol
  task automatic to_first_data(bit crc, logic [7:0] b);
    open_frame(2);
    host_write(b);
    request(crc);
    bus_eod();
    wait_sym(); ack();
    expect_sym(3'd1, b, "R2 first");
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) step();
    chk(!sym_valid_o && !tde_o && !req_crc_o && !req_nocrc_o, "reset",
        {sym_valid_o, tde_o, req_crc_o, req_nocrc_o}, 0);
    rst_ni = 1; step();

    // R1: request with no open frame
    request(1'b0); step();
    expect_idle("R1 no frame");

    // random complete responses (R2 R3 R4 R5 R9)
    for (int r = 0; r < 10; r++) begin
      int nh = $urandom_range(1, 4);
      int nb = $urandom_range(1, 5);
      bit cm = $urandom_range(0, 1);
      for (int i = 0; i < nb; i++) pl[i] = 8'($urandom);
      run_ifr(nh, nb, cm);
      step();
    end

    // R5: single byte with CRC, known vector
    pl[0] = 8'h00; run_ifr(1, 1, 1'b1);
    // R4: single byte no CRC
    pl[0] = 8'hA5; run_ifr(3, 1, 1'b0);

    // R1: late request after end-of-data
    request(1'b1);
    repeat (8) step();
    expect_idle("R1 late");

    // R11: tie goes to CRC; busy request ignored
    open_frame(1); host_write(8'h3C);
    req_crc_i = 1; req_nocrc_i = 1; step(); req_crc_i = 0; req_nocrc_i = 0;
    chk(req_crc_o && !req_nocrc_o, "R11 tie", {req_crc_o, req_nocrc_o}, 2);
    request(1'b0);
    chk(req_crc_o && !req_nocrc_o, "R11 busy", {req_crc_o, req_nocrc_o}, 2);
    bus_err_i = 1; step(); bus_err_i = 0;
    expect_idle("R7 armed");

    // R6: underrun
    to_first_data(1'b0, 8'h11);
    ack();
    expect_idle("R6 underrun");
    repeat (5) step();
    chk(!sym_valid_o, "R6 stays idle", sym_valid_o, 0);

    // R7: bus error during data
    to_first_data(1'b1, 8'h22);
    bus_err_i = 1; step(); bus_err_i = 0;
    expect_idle("R7 bus err");

    // R8: arbitration lost mid-byte
    to_first_data(1'b0, 8'h33);
    arb_lost_i = 1; step(); arb_lost_i = 0;
    expect_idle("R8 arb");
    repeat (6) step();
    chk(!sym_valid_o, "R8 no resend", sym_valid_o, 0);

    // R8: arbitration lost on last bit
    to_first_data(1'b1, 8'h44);
    arb_lost_i = 1; arb_last_bit_i = 1; step(); arb_lost_i = 0; arb_last_bit_i = 0;
    expect_sym(3'd4, 8'h00, "R8 ones");
    chk(!req_crc_o, "R8 req clr", req_crc_o, 0);
    step(); step();
    chk(sym_valid_o && sym_kind_o == 3'd4, "R12 ones held", sym_kind_o, 4);
    ack();
    expect_idle("R8 after ones");

    // R10: limit hit on a data byte, then on the CRC byte
    for (int i = 0; i < 4; i++) pl[i] = 8'h50 + 8'(i);
    run_ifr(9, 4, 1'b0);
    run_ifr(10, 2, 1'b1);
    // R10: exactly at limit passes
    run_ifr(8, 3, 1'b1);

    step();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule